// File: doc/BRIEF.md
# Dual-Reload PWM Timer Channel

This block is a single down-counting timer channel. It runs either as a plain periodic timer or as a pulse-width generator. In pulse-width mode the channel holds two reload values, one for the low phase and one for the high phase of its output. The output period is therefore the sum of two widths that are set separately, not one compare threshold. Each phase lasts at least one clock, so the output can never sit at 0 % or 100 % duty.

Software drives a small register port. Through it, software writes the two reload values and a control word, and reads back the live count. Each time the count expires, a raw interrupt flag is set. That flag drives a maskable interrupt line and is cleared by a read of an acknowledge address.

Register map (3-bit address):

| Address | Access | Contents |
|---------|--------|----------|
| 0 | read/write | control: bit0 run, bit1 reload mode (1 = reload from the reload values, 0 = free wrap), bit2 interrupt mask, bit3 toggle output |
| 1 | read/write | low-phase reload |
| 2 | read/write | high-phase reload |
| 3 | read-only | live count |
| 4 | read-only | status: bit0 raw flag, bit1 interrupt line |
| 5 | read | acknowledge: returns the raw flag and clears it |

Top module: `dual_reload_pwm_timer`

## Requirements
- R1: After reset, the output and the interrupt are low, and the control word, both reload values, the count and the status all read 0. Read data appears on the clock edge that samples `rd_en`, and is held until the next read.
- R2: In toggle mode with reload mode set, a write that sets run leaves the output low for (low reload + 1) cycles, then high for (high reload + 1) cycles, and the pattern repeats.
- R3: With both reloads at 0, the output alternates every cycle, starting low.
- R4: In reload mode without toggle, the count runs from the low reload down to 0 and then reloads the low reload value, and the output stays low.
- R5: In free mode, the count wraps from 0 to all ones and keeps counting down.
- R6: A reload write while the channel runs does not change the count in progress. It takes effect at the next load of that phase.
- R7: Clearing run drives the output low and freezes the count. The control word and the reload values keep what was written.
- R8: Each expiry sets the raw flag. The interrupt line equals the flag while the mask bit is 0 and is low while the mask bit is 1. A read of address 5 returns the flag in bit 0 and clears it.
- R9: Setting run after a stop loads the low reload value into the count and starts with the low phase.
- R10: A write to the live-count address has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Registered read data |
| pwm_out | output | 1 | Pulse-width output |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest case to reach is a reload write that lands while a phase is still counting down. The old value must finish that phase, and the new value must appear only when that phase is loaded again. The stimulus starts the channel, rewrites the low reload on the very next cycle, and then checks the output cycle by cycle across two full periods. The interrupt flag is also awkward, because it re-arms on every expiry. To pin it down, the channel is stopped just after an expiry, and the mask and acknowledge are then exercised on a frozen flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_LO     = 3'd1;
  localparam logic [ADDR_W-1:0] A_HI     = 3'd2;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;
  localparam logic [ADDR_W-1:0] A_ACK    = 3'd5;

  localparam int CTRL_W = 4;

  typedef struct packed {
    logic toggle;
    logic mask;
    logic reload;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              flag,
  input  logic              irq,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  lo_reload,
  output logic [CNT_W-1:0]  hi_reload,
  output logic              start,
  output logic              halt,
  output logic              ack,
  output logic [CNT_W-1:0]  rdata
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] lo_q, lo_d, hi_q, hi_d, rd_q, rd_d;
  logic             ctrl_we, lo_we, hi_we;

  assign ctrl_we = wr_en && (addr == A_CTRL);
  assign lo_we   = wr_en && (addr == A_LO);
  assign hi_we   = wr_en && (addr == A_HI);

  assign start = ctrl_we &&  wdata[0] && !ctrl_q.run;
  assign halt  = ctrl_we && !wdata[0] &&  ctrl_q.run;
  assign ack   = rd_en && (addr == A_ACK);

  always_comb begin
    ctrl_d = ctrl_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    if (ctrl_we) ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
    if (lo_we)   lo_d   = wdata;
    if (hi_we)   hi_d   = wdata;
  end

  always_comb begin
    rd_d = '0;
    unique case (addr)
      A_CTRL:   rd_d[CTRL_W-1:0] = ctrl_q;
      A_LO:     rd_d = lo_q;
      A_HI:     rd_d = hi_q;
      A_COUNT:  rd_d = count;
      A_STATUS: rd_d[1:0] = {irq, flag};
      A_ACK:    rd_d[0] = flag;
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      rd_q   <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_d;
      if (lo_we)   lo_q   <= lo_d;
      if (hi_we)   hi_q   <= hi_d;
      if (rd_en)   rd_q   <= rd_d;
    end
  end

  assign ctrl      = ctrl_q;
  assign lo_reload = lo_q;
  assign hi_reload = hi_q;
  assign rdata     = rd_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             reload_mode,
  input  logic             toggle_mode,
  input  logic             start,
  input  logic             halt,
  input  logic [CNT_W-1:0] lo_reload,
  input  logic [CNT_W-1:0] hi_reload,
  output logic [CNT_W-1:0] count,
  output logic             phase,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ph_q, ph_d;
  logic             go, cnt_en, at_zero;

  assign go      = run && !halt;
  assign cnt_en  = start || go;
  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    ph_d   = ph_q;
    expire = 1'b0;
    if (start) begin
      cnt_d = lo_reload;
      ph_d  = 1'b0;
    end else if (!go) begin
      ph_d  = 1'b0;
    end else if (at_zero) begin
      expire = 1'b1;
      if (toggle_mode) ph_d = !ph_q;
      if (reload_mode) cnt_d = (toggle_mode && !ph_q) ? hi_reload : lo_reload;
      else             cnt_d = cnt_q - 1'b1;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      ph_q <= ph_d;
    end
  end

  assign count = cnt_q;
  assign phase = ph_q;
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic ack,
  input  logic mask,
  output logic flag,
  output logic irq
);
  logic flag_q, flag_d, flag_en;

  assign flag_en = expire || ack;

  always_comb begin
    flag_d = flag_q;
    if (expire)   flag_d = 1'b1;
    else if (ack) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag = flag_q;
  assign irq  = flag_q && !mask;
endmodule

// File: rtl/dual_reload_pwm_timer.sv
module dual_reload_pwm_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              pwm_out,
  output logic              irq
);
  logic             core_rst_n;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] lo_reload, hi_reload, count;
  logic             start, halt, ack, phase, expire, flag;

  tmr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(core_rst_n)
  );

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(core_rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .count(count), .flag(flag), .irq(irq),
    .ctrl(ctrl), .lo_reload(lo_reload), .hi_reload(hi_reload),
    .start(start), .halt(halt), .ack(ack), .rdata(rdata)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(core_rst_n), .run(ctrl.run),
    .reload_mode(ctrl.reload), .toggle_mode(ctrl.toggle),
    .start(start), .halt(halt), .lo_reload(lo_reload),
    .hi_reload(hi_reload), .count(count), .phase(phase), .expire(expire)
  );

  tmr_irq u_irq (
    .clk(clk), .rst_n(core_rst_n), .expire(expire), .ack(ack),
    .mask(ctrl.mask), .flag(flag), .irq(irq)
  );

  assign pwm_out = phase && ctrl.toggle && ctrl.run;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             reload_mode,
  input logic             toggle_mode,
  input logic             mask,
  input logic             start,
  input logic             halt,
  input logic             ack,
  input logic             expire,
  input logic             flag,
  input logic             irq,
  input logic             phase,
  input logic             pwm_out,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] lo_reload,
  input logic [CNT_W-1:0] hi_reload
);
  assert_start_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!pwm_out && count == $past(lo_reload)));

  assert_stop_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !pwm_out);

  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> $stable(count));

  assert_user_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !halt && reload_mode && !toggle_mode && count == '0)
      |=> count == $past(lo_reload));

  assert_high_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !halt && reload_mode && toggle_mode && count == '0 && !phase)
      |=> (phase && count == $past(hi_reload)));

  assert_free_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !halt && !reload_mode && count == '0) |=> count == '1);

  assert_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mask |-> !irq);

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !expire) |=> !flag);
endmodule

bind dual_reload_pwm_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(core_rst_n), .run(ctrl.run), .reload_mode(ctrl.reload),
  .toggle_mode(ctrl.toggle), .mask(ctrl.mask), .start(start), .halt(halt),
  .ack(ack), .expire(expire), .flag(flag), .irq(irq), .phase(phase),
  .pwm_out(pwm_out), .count(count), .lo_reload(lo_reload),
  .hi_reload(hi_reload)
);

// File: tb/sim_dual_reload_pwm_timer.sv
module sim_dual_reload_pwm_timer;
  localparam int W = 32;
  localparam logic [2:0] A_CTRL = 3'd0, A_LO = 3'd1, A_HI = 3'd2,
                         A_COUNT = 3'd3, A_STATUS = 3'd4, A_ACK = 3'd5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [2:0]   addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         pwm_out, irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic         rd_seen = 1'b0;

  always #10 clk = ~clk;

  dual_reload_pwm_timer #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [W-1:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // scoreboard monitor
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1 unexpected read", rdata, '0);
      end else begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rdata === e, t, rdata, e);
      end
    end
  end

  task automatic out_is(input logic e, input string tag);
    chk(pwm_out === e, tag, {31'd0, pwm_out}, {31'd0, e});
  endtask

  task automatic samp(input int lo, input int hi, input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      out_is((k % (lo + hi + 2)) >= (lo + 1), tag);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    out_is(1'b0, "R1 output after reset");
    chk(irq === 1'b0, "R1 irq after reset", {31'd0, irq}, '0);
    rd(A_CTRL,   '0, "R1 ctrl reset");
    rd(A_LO,     '0, "R1 low reload reset");
    rd(A_HI,     '0, "R1 high reload reset");
    rd(A_COUNT,  '0, "R1 count reset");
    rd(A_STATUS, '0, "R1 status reset");

    // R2 basic waveform
    wr(A_LO, 32'd2);
    wr(A_HI, 32'd4);
    wr(A_CTRL, 32'hB);
    samp(2, 4, 24, "R2 waveform lo=2 hi=4");

    // R3 minimum widths
    wr(A_CTRL, 32'hA);
    out_is(1'b0, "R7 output low after stop");
    wr(A_LO, 32'd0);
    wr(A_HI, 32'd0);
    wr(A_CTRL, 32'hB);
    samp(0, 0, 10, "R3 alternate each cycle");

    // R6 reload write during a running phase
    wr(A_CTRL, 32'hA);
    wr(A_LO, 32'd5);
    wr(A_HI, 32'd5);
    wr(A_CTRL, 32'hB);
    wr(A_LO, 32'd1);
    for (int k = 0; k < 27; k++) begin
      logic e;
      if (k < 5)       e = 1'b0;
      else if (k < 11) e = 1'b1;
      else             e = (((k - 11) % 8) >= 2);
      out_is(e, "R6 late reload write");
      @(negedge clk);
    end

    // R7 stop keeps configuration and drives output low
    wr(A_CTRL, 32'hA);
    for (int k = 0; k < 4; k++) begin
      out_is(1'b0, "R7 output low while stopped");
      @(negedge clk);
    end
    rd(A_LO,   32'd1, "R7 low reload kept");
    rd(A_HI,   32'd5, "R7 high reload kept");
    rd(A_CTRL, 32'hA, "R7 ctrl kept");

    // R4 reload mode without toggle
    wr(A_CTRL, 32'h2);
    wr(A_LO, 32'd3);
    wr(A_CTRL, 32'h3);
    rd(A_COUNT, 32'd3, "R4 count 3");
    rd(A_COUNT, 32'd2, "R4 count 2");
    rd(A_COUNT, 32'd1, "R4 count 1");
    rd(A_COUNT, 32'd0, "R4 count 0");
    rd(A_COUNT, 32'd3, "R4 reload to 3");
    out_is(1'b0, "R4 output stays low");

    // R5 free wrap
    wr(A_CTRL, 32'h0);
    wr(A_LO, 32'd2);
    wr(A_CTRL, 32'h1);
    rd(A_COUNT, 32'd2,        "R5 count 2");
    rd(A_COUNT, 32'd1,        "R5 count 1");
    rd(A_COUNT, 32'd0,        "R5 count 0");
    rd(A_COUNT, 32'hFFFFFFFF, "R5 wrap to all ones");
    rd(A_COUNT, 32'hFFFFFFFE, "R5 keeps counting");

    // R7 count frozen on stop
    wr(A_CTRL, 32'h2);
    rd(A_COUNT, 32'hFFFFFFFD, "R7 count frozen");
    rd(A_COUNT, 32'hFFFFFFFD, "R7 count still frozen");

    // R9 restart loads the low reload
    wr(A_LO, 32'd7);
    wr(A_HI, 32'd1);
    wr(A_CTRL, 32'hB);
    rd(A_COUNT, 32'd7, "R9 count loaded on restart");
    rd(A_COUNT, 32'd6, "R9 counting after restart");
    out_is(1'b0, "R9 starts low");

    // R10 count address is read-only
    wr(A_CTRL, 32'hA);
    wr(A_COUNT, 32'h1234);
    rd(A_COUNT, 32'd5, "R10 count write ignored");

    // R8 interrupt flag, mask and acknowledge
    rd(A_ACK, 32'd1, "R8 earlier expiries set flag");
    rd(A_STATUS, 32'd0, "R8 flag cleared by acknowledge");
    chk(irq === 1'b0, "R8 irq low after acknowledge", {31'd0, irq}, '0);
    wr(A_CTRL, 32'h2);
    wr(A_LO, 32'd1);
    wr(A_CTRL, 32'h3);
    @(negedge clk);
    @(negedge clk);
    wr(A_CTRL, 32'h2);
    chk(irq === 1'b1, "R8 irq after expiry", {31'd0, irq}, 32'd1);
    rd(A_STATUS, 32'd3, "R8 status flag and irq");
    wr(A_CTRL, 32'h6);
    chk(irq === 1'b0, "R8 irq masked", {31'd0, irq}, '0);
    rd(A_STATUS, 32'd1, "R8 raw flag kept under mask");
    wr(A_CTRL, 32'h2);
    chk(irq === 1'b1, "R8 irq unmasked", {31'd0, irq}, 32'd1);
    rd(A_ACK, 32'd1, "R8 acknowledge returns flag");
    chk(irq === 1'b0, "R8 irq cleared", {31'd0, irq}, '0);
    rd(A_STATUS, 32'd0, "R8 status after acknowledge");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R1 pending reads drained", exp_q.size(), '0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule